// File: doc/BRIEF.md
# ATA Device Task-File Register and Status Unit

This block is the device side of an ATA register file. The host reaches eight byte-wide offsets through a simple strobed access port. Offsets two to six are plain parameter registers: sector count, the three address bytes and device select. Offset one reads the error register. Offset seven takes a command on write and returns status on read. Offset zero is the 16-bit data port.

Behind the registers sits a small command sequencer. IDENTIFY streams 256 words out of an internal, computed ROM through the data port. FLUSH CACHE holds the unit busy until an external completion pulse arrives. Any other opcode is aborted at once.

An interrupt request is raised when the identify block becomes ready, when a flush completes and when a command aborts. A status read clears it. A mask input gates the interrupt pin without discarding the pending request.

Top module: `ata_taskfile`

## Requirements
- R1: After reset, status reads 0x0040 (DRDY only), the error register and offsets 2 to 6 read 0x0000, and irq is low.
- R2: Writes to offsets 2 to 6 are read back unchanged from the same offset, zero-extended to 16 bits. A write to offset 0 or offset 1 changes no readable register.
- R3: While BSY (status bit 7) is set, writes to offsets 2 to 6 are ignored.
- R4: Writing 0xEC to offset 7 raises irq and sets status to 0x0048 (DRDY bit 6, DRQ bit 3). The next 256 reads of offset 0 return identify words 0 to 255 in order. Words 10 to 19 hold the serial text "QSIM-DISK-0000000042" and words 23 to 26 hold the version text "FW01.00 ", each word carrying two characters with the first one in the high byte. Word 85 is 0x0020 (write cache enabled, bit 5). Every other word is 0x0000.
- R5: After the 256th identify read, status returns to 0x0040. A read of offset 0 while DRQ is clear returns 0x0000.
- R6: Writing 0xE7 to offset 7 sets status to 0x00C0 (BSY and DRDY) until a one-cycle flushDone pulse. After the pulse, status is 0x0040 and irq is raised.
- R7: Writing any opcode other than 0xEC or 0xE7 to offset 7 sets status to 0x0041 (ERR bit 0), sets the error register to 0x0004 (ABRT bit 2) and raises irq. The next accepted IDENTIFY or FLUSH clears both.
- R8: A read of offset 7 clears the pending interrupt. irq equals the pending request gated by intDisable, and masking does not discard a pending request.
- R9: A command written to offset 7 while BSY is set is still accepted and replaces the running flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register offset for the current access |
| wrEn | input | 1 | Write strobe, one access per cycle |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe; read side effects take place at the clock edge |
| rdData | output | 16 | Combinational read data for regAddr |
| flushDone | input | 1 | Completion pulse for a flush in progress |
| intDisable | input | 1 | Masks the irq output |
| irq | output | 1 | Interrupt request to the host |

## Verification
The embedded properties check several behaviours on every cycle. A flush stays busy until its completion pulse and releases on that pulse. DRQ drops after the final identify read. A status read leaves no pending interrupt. Parameter registers stay frozen under BSY, and an unknown opcode always lands in the error state. The bench scenarios are needed for the rest: the exact contents and order of the 256 identify words, the visible register values after each command, and how the mask interacts with a request that is already pending. Replacing a flush with a new command is also shown only by scenario.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  localparam logic [2:0] REG_DATA   = 3'd0;
  localparam logic [2:0] REG_ERROR  = 3'd1;
  localparam logic [2:0] REG_COUNT  = 3'd2;
  localparam logic [2:0] REG_DEVICE = 3'd6;
  localparam logic [2:0] REG_CMD    = 3'd7;

  localparam logic [7:0] OPC_IDENTIFY = 8'hEC;
  localparam logic [7:0] OPC_FLUSH    = 8'hE7;

  localparam int SER_FIRST = 10;
  localparam int SER_LEN   = 20;
  localparam int VER_FIRST = 23;
  localparam int VER_LEN   = 8;
  localparam int CACHE_WORD = 85;

  localparam logic [8*SER_LEN-1:0] SERIAL_TEXT  = "QSIM-DISK-0000000042";
  localparam logic [8*VER_LEN-1:0] VERSION_TEXT = "FW01.00 ";

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FLUSH = 2'd1,
    ST_PIO   = 2'd2
  } ctlState_t;

  typedef struct packed {
    logic tfWrite;
    logic errSet;
    logic errClr;
    logic cntClr;
    logic cntInc;
    logic irqSet;
  } dpStrobe_t;

  function automatic logic [15:0] idWord(input int idx);
    logic [15:0] w;
    int k;
    w = '0;
    k = 0;
    if (idx >= SER_FIRST && idx < SER_FIRST + SER_LEN/2) begin
      k = 2*(idx - SER_FIRST);
      w = {SERIAL_TEXT[8*(SER_LEN-1-k) +: 8], SERIAL_TEXT[8*(SER_LEN-2-k) +: 8]};
    end else if (idx >= VER_FIRST && idx < VER_FIRST + VER_LEN/2) begin
      k = 2*(idx - VER_FIRST);
      w = {VERSION_TEXT[8*(VER_LEN-1-k) +: 8], VERSION_TEXT[8*(VER_LEN-2-k) +: 8]};
    end else if (idx == CACHE_WORD) begin
      w = 16'h0020;
    end
    return w;
  endfunction

endpackage

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
  import ata_tf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regAddr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       rdEn,
  input  logic       flushDone,
  input  logic       lastWord,
  output dpStrobe_t  strb,
  output logic       busy,
  output logic       drq
);

  ctlState_t state, stateNxt;
  logic cmdWr;
  logic dataRd;

  assign cmdWr  = wrEn && (regAddr == REG_CMD);
  assign dataRd = rdEn && (regAddr == REG_DATA);

  always_comb begin
    stateNxt = state;
    strb = '0;
    strb.tfWrite = wrEn && (regAddr >= REG_COUNT) && (regAddr <= REG_DEVICE)
                   && (state != ST_FLUSH);
    if (cmdWr) begin
      unique case (wrData)
        OPC_IDENTIFY: begin
          stateNxt    = ST_PIO;
          strb.cntClr = 1'b1;
          strb.errClr = 1'b1;
          strb.irqSet = 1'b1;
        end
        OPC_FLUSH: begin
          stateNxt    = ST_FLUSH;
          strb.errClr = 1'b1;
        end
        default: begin
          stateNxt    = ST_IDLE;
          strb.errSet = 1'b1;
          strb.irqSet = 1'b1;
        end
      endcase
    end else begin
      unique case (state)
        ST_FLUSH: begin
          if (flushDone) begin
            stateNxt    = ST_IDLE;
            strb.irqSet = 1'b1;
          end
        end
        ST_PIO: begin
          if (dataRd) begin
            strb.cntInc = 1'b1;
            if (lastWord) stateNxt = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign busy = (state == ST_FLUSH);
  assign drq  = (state == ST_PIO);

  AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !flushDone && !cmdWr) |=> busy); // R6
  AST_FLUSH_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && flushDone && !cmdWr) |=> (!busy && !drq)); // R6
  AST_ID_END: assert property (@(posedge clk) disable iff (!rstN)
    (drq && dataRd && lastWord && !cmdWr) |=> !drq); // R5

endmodule

// File: rtl/ata_tf_datapath.sv
module ata_tf_datapath
  import ata_tf_pkg::*;
#(
  parameter int ID_WORDS = 256,
  parameter int TF_REGS  = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  input  logic        rdEn,
  input  dpStrobe_t   strb,
  input  logic        busy,
  input  logic        drq,
  input  logic        intDisable,
  output logic [15:0] rdData,
  output logic        lastWord,
  output logic        irq
);

  localparam int CNT_W = $clog2(ID_WORDS);

  logic [TF_REGS-1:0][7:0] tfRegs;
  logic [CNT_W-1:0]        wordCnt;
  logic                    errFlag;
  logic                    irqPend;
  logic [7:0]              statusByte;
  logic                    statusRd;

  for (genvar g = 0; g < TF_REGS; g++) begin : g_tf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) tfRegs[g] <= '0;
      else if (strb.tfWrite && regAddr == 3'(int'(REG_COUNT) + g)) tfRegs[g] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wordCnt <= '0;
    else if (strb.cntClr) wordCnt <= '0;
    else if (strb.cntInc) wordCnt <= wordCnt + 1'b1;
  end

  assign lastWord = (wordCnt == CNT_W'(ID_WORDS-1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            errFlag <= 1'b0;
    else if (strb.errSet) errFlag <= 1'b1;
    else if (strb.errClr) errFlag <= 1'b0;
  end

  assign statusRd = rdEn && (regAddr == REG_CMD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            irqPend <= 1'b0;
    else if (strb.irqSet) irqPend <= 1'b1;
    else if (statusRd)    irqPend <= 1'b0;
  end

  assign irq = irqPend && !intDisable;

  assign statusByte = {busy, 1'b1, 1'b0, 1'b0, drq, 2'b00, errFlag};

  always_comb begin
    rdData = '0;
    if (regAddr == REG_DATA) begin
      if (drq) rdData = idWord(int'(wordCnt));
    end else if (regAddr == REG_ERROR) begin
      rdData = {13'd0, errFlag, 2'b00};
    end else if (regAddr == REG_CMD) begin
      rdData = {8'h00, statusByte};
    end else begin
      for (int i = 0; i < TF_REGS; i++) begin
        if (regAddr == 3'(int'(REG_COUNT) + i)) rdData = {8'h00, tfRegs[i]};
      end
    end
  end

  AST_STATUS_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !strb.irqSet) |=> !irqPend); // R8
  AST_TF_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && regAddr != REG_CMD) |=> $stable(tfRegs)); // R3
  AST_BAD_OPCODE_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == REG_CMD && wrData != OPC_IDENTIFY && wrData != OPC_FLUSH)
      |=> (errFlag && irqPend)); // R7

endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_tf_pkg::*;
#(
  parameter int ID_WORDS = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        wrEn,
  input  logic [7:0]  wrData,
  input  logic        rdEn,
  output logic [15:0] rdData,
  input  logic        flushDone,
  input  logic        intDisable,
  output logic        irq
);

  dpStrobe_t strb;
  logic busy;
  logic drq;
  logic lastWord;

  ata_tf_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .rdEn      (rdEn),
    .flushDone (flushDone),
    .lastWord  (lastWord),
    .strb      (strb),
    .busy      (busy),
    .drq       (drq)
  );

  ata_tf_datapath #(
    .ID_WORDS (ID_WORDS),
    .TF_REGS  (5)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .rdEn       (rdEn),
    .strb       (strb),
    .busy       (busy),
    .drq        (drq),
    .intDisable (intDisable),
    .rdData     (rdData),
    .lastWord   (lastWord),
    .irq        (irq)
  );

endmodule

// File: tb/ata_taskfile_tb_top.sv
module ata_taskfile_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 37;

  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_DN  = 2'd2;
  localparam logic [1:0] OP_IRQ = 2'd3;

  // {op, addr, data/expected, requirement number}
  localparam logic [24:0] VEC [0:N_VEC-1] = '{
    {OP_WR, 3'd2, 16'h005A, 4'd2},  // R2
    {OP_RD, 3'd2, 16'h005A, 4'd2},  // R2
    {OP_WR, 3'd3, 16'h0011, 4'd2},
    {OP_WR, 3'd4, 16'h0022, 4'd2},
    {OP_WR, 3'd5, 16'h0033, 4'd2},
    {OP_WR, 3'd6, 16'h0050, 4'd2},
    {OP_RD, 3'd3, 16'h0011, 4'd2},
    {OP_RD, 3'd4, 16'h0022, 4'd2},
    {OP_RD, 3'd5, 16'h0033, 4'd2},
    {OP_RD, 3'd6, 16'h0050, 4'd2},
    {OP_WR, 3'd0, 16'h00FF, 4'd2},
    {OP_WR, 3'd1, 16'h00FF, 4'd2},
    {OP_RD, 3'd0, 16'h0000, 4'd5},  // R5 data port idle
    {OP_RD, 3'd1, 16'h0000, 4'd2},
    {OP_RD, 3'd2, 16'h005A, 4'd2},
    {OP_WR, 3'd7, 16'h0000, 4'd7},  // R7 unknown opcode
    {OP_IRQ, 3'd0, 16'h0001, 4'd7},
    {OP_RD, 3'd1, 16'h0004, 4'd7},
    {OP_RD, 3'd7, 16'h0041, 4'd7},
    {OP_IRQ, 3'd0, 16'h0000, 4'd8}, // R8 cleared by status read
    {OP_WR, 3'd7, 16'h00E7, 4'd6},  // R6 flush
    {OP_RD, 3'd7, 16'h00C0, 4'd6},
    {OP_RD, 3'd1, 16'h0000, 4'd7},
    {OP_IRQ, 3'd0, 16'h0000, 4'd6},
    {OP_WR, 3'd2, 16'h0077, 4'd3},  // R3 ignored under BSY
    {OP_WR, 3'd6, 16'h0010, 4'd3},
    {OP_RD, 3'd2, 16'h005A, 4'd3},
    {OP_RD, 3'd6, 16'h0050, 4'd3},
    {OP_RD, 3'd7, 16'h00C0, 4'd6},
    {OP_DN, 3'd0, 16'h0000, 4'd6},
    {OP_IRQ, 3'd0, 16'h0001, 4'd6},
    {OP_RD, 3'd7, 16'h0040, 4'd6},
    {OP_IRQ, 3'd0, 16'h0000, 4'd8},
    {OP_WR, 3'd7, 16'h00E7, 4'd9},  // R9 command during busy
    {OP_RD, 3'd7, 16'h00C0, 4'd9},
    {OP_WR, 3'd7, 16'h0000, 4'd9},
    {OP_RD, 3'd7, 16'h0041, 4'd9}
  };

  logic        clk;
  logic        rstN;
  logic [2:0]  regAddr;
  logic        wrEn;
  logic [7:0]  wrData;
  logic        rdEn;
  logic [15:0] rdData;
  logic        flushDone;
  logic        intDisable;
  logic        irq;

  int checks;
  int failures;
  bit finished;

  ata_taskfile dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .rdEn       (rdEn),
    .rdData     (rdData),
    .flushDone  (flushDone),
    .intDisable (intDisable),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] expWord(input int i);
    string ser;
    string ver;
    ser = "QSIM-DISK-0000000042";
    ver = "FW01.00 ";
    if (i >= 10 && i <= 19) return {ser[2*(i-10)], ser[2*(i-10)+1]};
    if (i >= 23 && i <= 26) return {ver[2*(i-23)], ver[2*(i-23)+1]};
    if (i == 85) return 16'h0020;
    return 16'h0000;
  endfunction

  task automatic doWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    regAddr = a; rdEn = 1'b1;
    #1;
    checks++;
    if (rdData !== exp) begin
      failures++;
      $display("FAIL %s read offset %0d: actual 0x%04h expected 0x%04h", req, a, rdData, exp);
    end
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic checkIrq(input logic exp, input string req);
    @(negedge clk);
    #1;
    checks++;
    if (irq !== exp) begin
      failures++;
      $display("FAIL %s irq: actual %0b expected %0b", req, irq, exp);
    end
  endtask

  task automatic pulseDone();
    @(negedge clk);
    flushDone = 1'b1;
    @(negedge clk);
    flushDone = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [24:0] v;
    string tag;
    checks = 0; failures = 0; finished = 1'b0;
    rstN = 1'b0; regAddr = '0; wrEn = 1'b0; wrData = '0; rdEn = 1'b0;
    flushDone = 1'b0; intDisable = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    checkIrq(1'b0, "R1");
    doRead(3'd7, 16'h0040, "R1");
    doRead(3'd1, 16'h0000, "R1");
    for (int a = 2; a <= 6; a++) doRead(3'(a), 16'h0000, "R1");

    // vector table
    for (int n = 0; n < N_VEC; n++) begin
      v = VEC[n];
      tag = $sformatf("R%0d", v[3:0]);
      case (v[24:23])
        OP_WR:  doWrite(v[22:20], v[11:4]);
        OP_RD:  doRead(v[22:20], v[19:4], tag);
        OP_DN:  pulseDone();
        default: checkIrq(v[4], tag);
      endcase
    end

    // R4 identify stream; R7 error cleared by accepted command
    doWrite(3'd7, 8'hEC);
    checkIrq(1'b1, "R4");
    doRead(3'd1, 16'h0000, "R7");
    for (int i = 0; i < 256; i++) begin
      doRead(3'd7, 16'h0048, "R4");
      doRead(3'd0, expWord(i), "R4");
    end
    // R5 end of stream
    doRead(3'd7, 16'h0040, "R5");
    doRead(3'd0, 16'h0000, "R5");
    checkIrq(1'b0, "R5");

    // R8 masking keeps the pending request
    intDisable = 1'b1;
    doWrite(3'd7, 8'h00);
    checkIrq(1'b0, "R8");
    intDisable = 1'b0;
    checkIrq(1'b1, "R8");
    doRead(3'd7, 16'h0041, "R8");
    checkIrq(1'b0, "R8");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule